// File: doc/BRIEF.md
# UART Interrupt Priority Identifier

This block merges the interrupt causes of a 16550-style serial port into one interrupt request and the byte that software reads back from the interrupt identification register. It sits beside the receive FIFO, the transmitter and the modem-line logic. Those neighbours supply status flags and bus strobes. The block picks the most urgent enabled cause and encodes it in the low nibble of the identification byte.

The block holds three things itself: the 4-bit enable register, the hidden "transmit holding empty" pending flag, and the registered identification byte and request line. The pending flag is set when the holding register drains, or when software writes the enable register while the holding register is empty. It is cleared when software writes the holding register, or when software reads the identification byte while that byte reports transmit-empty.

Every output is registered. The identification byte and the request line reflect the inputs sampled at the previous clock edge and the state updated at that edge.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, `iir` reads 0x01, `irq` is low, `ier_q` is 0 and the transmit pending flag is clear.
- R2: When `ier_q` bit 2 is set and any bit of `lsr_err` is set, the low nibble is 0x06. This cause wins over every other cause.
- R3: When `timeout_pend` is set and `ier_q` bit 0 is set, the low nibble is 0x0C, unless R2 applies. With `ier_q` bit 0 clear, a pending timeout never produces 0x0C.
- R4: The receive-data cause requires `ier_q` bit 0 and `rx_ready`. With `fifo_en` set it also requires `rx_count` to be at least the trigger level. `trig_sel` codes 0, 1, 2 and 3 select levels 1, 4, 8 and 14 at depth 16. With `fifo_en` clear, `rx_ready` alone is enough. When this cause is the highest one present, the low nibble is 0x04.
- R5: The transmit pending flag follows these rules, in order of precedence:
  - `thr_wr` clears it.
  - Otherwise `thr_drained`, or `ier_wr` while `thr_empty` is set, sets it.
  - Otherwise it holds.

  When the flag is set and `ier_q` bit 1 is set, the low nibble is 0x02, provided no higher cause is present.
- R6: An `iir_rd` in a cycle where `iir` shows low nibble 0x02 clears the pending flag, unless R5 sets or clears it in the same cycle. An `iir_rd` while any other code is shown leaves the flag unchanged.
- R7: When `ier_q` bit 3 is set and any bit of `msr_delta` is set, the low nibble is 0x00, provided no higher cause is present.
- R8: `iir` bits 7:6 read 11 when `fifo_en` is set and 00 when it is clear. Bits 5:4 always read 0.
- R9: `irq` is high exactly when the low nibble of `iir` is not 0x01. The low nibble is 0x01 when no enabled cause is present.
- R10: `ier_wr` loads `ier_wr_data` into `ier_q`. The new enables take effect in the same update as the write.
- R11: `iir`, `irq` and `ier_q` change one clock edge after the inputs that cause the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ier_wr | input | 1 | Write strobe for the enable register |
| ier_wr_data | input | 4 | Enables: bit0 receive data and timeout, bit1 transmit empty, bit2 line status, bit3 modem status |
| thr_wr | input | 1 | Write strobe for the transmit holding register |
| thr_drained | input | 1 | One-cycle pulse when the holding register or FIFO becomes empty |
| thr_empty | input | 1 | Holding register currently empty |
| iir_rd | input | 1 | Read strobe for the identification register |
| lsr_err | input | 4 | Break, framing, parity and overrun flags |
| rx_ready | input | 1 | Receive data ready |
| rx_count | input | CNT_W | Receive FIFO fill count |
| trig_sel | input | 2 | Receive trigger level select |
| timeout_pend | input | 1 | Character timeout pending |
| msr_delta | input | 4 | Modem status delta bits |
| fifo_en | input | 1 | FIFO mode enabled |
| ier_q | output | 4 | Current enable register |
| iir | output | 8 | Identification register value |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is the hidden pending flag under interference. Examples are a read of the identification byte that coincides with a holding-register write, a drain pulse, or an enable-register write, and a read taken while a higher cause masks the transmit code. The flag is only visible through the code it produces once every higher cause is absent. Directed sequences therefore set the flag, read while receive data masks it, and then drop the receive cause to show that the flag survived. Random cycles keep each cause sparse so that low-priority codes and strobe collisions both appear often.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int NUM_SRC = 5;

  // Source index, 0 is the most urgent
  localparam int SRC_LINE = 0;
  localparam int SRC_TMO  = 1;
  localparam int SRC_RXD  = 2;
  localparam int SRC_THRE = 3;
  localparam int SRC_MDM  = 4;

  localparam logic [3:0] CODE_NONE = 4'h1;

  function automatic logic [3:0] src_code(input int idx);
    case (idx)
      SRC_LINE: src_code = 4'h6;
      SRC_TMO:  src_code = 4'hC;
      SRC_RXD:  src_code = 4'h4;
      SRC_THRE: src_code = 4'h2;
      default:  src_code = 4'h0;
    endcase
  endfunction

  // Trigger level from select code, scaled to FIFO depth
  function automatic int trig_level(input logic [1:0] sel, input int depth);
    case (sel)
      2'd0:    trig_level = 1;
      2'd1:    trig_level = depth / 4;
      2'd2:    trig_level = depth / 2;
      default: trig_level = depth - 2;
    endcase
  endfunction

endpackage

// File: rtl/uart_irq_src.sv
module uart_irq_src
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic [3:0]       en,
  input  logic [3:0]       lsr_err,
  input  logic             rx_ready,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [1:0]       trig_sel,
  input  logic             timeout_pend,
  input  logic             thre_pend,
  input  logic [3:0]       msr_delta,
  input  logic             fifo_en,
  output logic [NUM_SRC-1:0] req
);

  logic             level_met;
  logic [CNT_W-1:0] level;

  always_comb begin
    level     = CNT_W'(trig_level(trig_sel, FIFO_DEPTH));
    level_met = (rx_count >= level);
  end

  always_comb begin
    req           = '0;
    req[SRC_LINE] = en[2] & (|lsr_err);
    req[SRC_TMO]  = en[0] & timeout_pend;
    req[SRC_RXD]  = en[0] & rx_ready & (~fifo_en | level_met);
    req[SRC_THRE] = en[1] & thre_pend;
    req[SRC_MDM]  = en[3] & (|msr_delta);
  end

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic [NUM_SRC-1:0] req,
  output logic [3:0]         code
);

  logic [NUM_SRC-1:0] grant;
  logic [NUM_SRC:0]   taken;

  assign taken[0] = 1'b0;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chain
    assign grant[i]   = req[i] & ~taken[i];
    assign taken[i+1] = taken[i] | req[i];
  end

  always_comb begin
    code = CODE_NONE;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (grant[i]) code = src_code(i);
    end
  end

endmodule

// File: rtl/uart_irq_thre.sv
module uart_irq_thre (
  input  logic clk,
  input  logic rst,
  input  logic thr_wr,
  input  logic thr_drained,
  input  logic ier_wr,
  input  logic thr_empty,
  input  logic iir_rd,
  input  logic shows_thre,
  output logic pend_nxt,
  output logic pend_q
);

  always_comb begin
    pend_nxt = pend_q;
    if (thr_wr)
      pend_nxt = 1'b0;
    else if (thr_drained || (ier_wr && thr_empty))
      pend_nxt = 1'b1;
    else if (iir_rd && shows_thre)
      pend_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else     pend_q <= pend_nxt;
  end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ier_wr,
  input  logic [3:0]       ier_wr_data,
  input  logic             thr_wr,
  input  logic             thr_drained,
  input  logic             thr_empty,
  input  logic             iir_rd,
  input  logic [3:0]       lsr_err,
  input  logic             rx_ready,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [1:0]       trig_sel,
  input  logic             timeout_pend,
  input  logic [3:0]       msr_delta,
  input  logic             fifo_en,
  output logic [3:0]       ier_q,
  output logic [7:0]       iir,
  output logic             irq
);

  logic [3:0]         ier_nxt;
  logic               pend_nxt;
  logic               pend_q;
  logic [NUM_SRC-1:0] req;
  logic [3:0]         code;
  logic [7:0]         iir_q;
  logic               irq_q;

  assign ier_nxt = ier_wr ? ier_wr_data : ier_q;

  uart_irq_thre u_thre (
    .clk        (clk),
    .rst        (rst),
    .thr_wr     (thr_wr),
    .thr_drained(thr_drained),
    .ier_wr     (ier_wr),
    .thr_empty  (thr_empty),
    .iir_rd     (iir_rd),
    .shows_thre (iir_q[3:0] == src_code(SRC_THRE)),
    .pend_nxt   (pend_nxt),
    .pend_q     (pend_q)
  );

  uart_irq_src #(
    .FIFO_DEPTH(FIFO_DEPTH),
    .CNT_W     (CNT_W)
  ) u_src (
    .en          (ier_nxt),
    .lsr_err     (lsr_err),
    .rx_ready    (rx_ready),
    .rx_count    (rx_count),
    .trig_sel    (trig_sel),
    .timeout_pend(timeout_pend),
    .thre_pend   (pend_nxt),
    .msr_delta   (msr_delta),
    .fifo_en     (fifo_en),
    .req         (req)
  );

  uart_irq_prio u_prio (
    .req (req),
    .code(code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ier_q <= '0;
      iir_q <= {4'h0, CODE_NONE};
      irq_q <= 1'b0;
    end else begin
      ier_q <= ier_nxt;
      iir_q <= {{2{fifo_en}}, 2'b00, code};
      irq_q <= (code != CODE_NONE);
    end
  end

  assign iir = iir_q;
  assign irq = irq_q;

endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             ier_wr,
  input logic             thr_wr,
  input logic             thr_drained,
  input logic             thr_empty,
  input logic             iir_rd,
  input logic [3:0]       lsr_err,
  input logic             timeout_pend,
  input logic [3:0]       msr_delta,
  input logic             fifo_en,
  input logic [3:0]       ier_q,
  input logic [7:0]       iir,
  input logic             irq
);

  logic past_ok;

  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  a_r9_irq_tracks_code: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (irq == (iir[3:0] != 4'h1)));

  a_r8_upper_bits: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (iir[7:4] == {{2{$past(fifo_en)}}, 2'b00}));

  a_r2_line_wins: assert property (@(posedge clk) disable iff (rst)
    (past_ok && ier_q[2] && $past(|lsr_err)) |-> (iir[3:0] == 4'h6));

  a_r3_timeout_gated: assert property (@(posedge clk) disable iff (rst)
    (past_ok && iir[3:0] == 4'hC) |-> (ier_q[0] && $past(timeout_pend)));

  a_r7_modem_cause: assert property (@(posedge clk) disable iff (rst)
    (past_ok && iir[3:0] == 4'h0) |-> (ier_q[3] && $past(|msr_delta)));

  a_r6_read_clears: assert property (@(posedge clk) disable iff (rst)
    (past_ok && iir_rd && iir[3:0] == 4'h2 && !thr_wr && !thr_drained &&
     !(ier_wr && thr_empty)) |=> (iir[3:0] != 4'h2));

endmodule

bind uart_irq_ident uart_irq_ident_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ier_wr      (ier_wr),
  .thr_wr      (thr_wr),
  .thr_drained (thr_drained),
  .thr_empty   (thr_empty),
  .iir_rd      (iir_rd),
  .lsr_err     (lsr_err),
  .timeout_pend(timeout_pend),
  .msr_delta   (msr_delta),
  .fifo_en     (fifo_en),
  .ier_q       (ier_q),
  .iir         (iir),
  .irq         (irq)
);

// File: tb/uart_irq_ident_tb_top.sv
`timescale 1ns/1ps
module uart_irq_ident_tb_top;

  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst;
  logic          ier_wr, thr_wr, thr_drained, thr_empty, iir_rd;
  logic [3:0]    ier_wr_data, lsr_err, msr_delta;
  logic          rx_ready, timeout_pend, fifo_en;
  logic [CW-1:0] rx_count;
  logic [1:0]    trig_sel;
  logic [3:0]    ier_q;
  logic [7:0]    iir;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [3:0] m_ier;
  logic       m_pend;
  logic [7:0] m_iir;

  always #5 clk = ~clk;

  uart_irq_ident #(.FIFO_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .ier_wr(ier_wr), .ier_wr_data(ier_wr_data),
    .thr_wr(thr_wr), .thr_drained(thr_drained), .thr_empty(thr_empty),
    .iir_rd(iir_rd), .lsr_err(lsr_err), .rx_ready(rx_ready),
    .rx_count(rx_count), .trig_sel(trig_sel), .timeout_pend(timeout_pend),
    .msr_delta(msr_delta), .fifo_en(fifo_en), .ier_q(ier_q), .iir(iir),
    .irq(irq)
  );

  function automatic int lvl(input logic [1:0] s);
    case (s)
      2'd0: lvl = 1;
      2'd1: lvl = 4;
      2'd2: lvl = 8;
      default: lvl = 14;
    endcase
  endfunction

  function automatic logic [7:0] exp_iir(input logic [3:0] e, input logic p);
    logic [3:0] c;
    if (e[2] && |lsr_err)                 c = 4'h6;
    else if (e[0] && timeout_pend)        c = 4'hC;
    else if (e[0] && rx_ready && (!fifo_en || int'(rx_count) >= lvl(trig_sel)))
                                          c = 4'h4;
    else if (e[1] && p)                   c = 4'h2;
    else if (e[3] && |msr_delta)          c = 4'h0;
    else                                  c = 4'h1;
    exp_iir = {{2{fifo_en}}, 2'b00, c};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic idle();
    ier_wr = 0; ier_wr_data = 0; thr_wr = 0; thr_drained = 0; iir_rd = 0;
    thr_empty = 0; lsr_err = 0; rx_ready = 0; rx_count = 0; trig_sel = 0;
    timeout_pend = 0; msr_delta = 0; fifo_en = 0;
  endtask

  // Called at negedge after inputs are set: advance model, wait one edge
  task automatic step();
    logic [3:0] ne;
    logic       np;
    ne = ier_wr ? ier_wr_data : m_ier;
    np = m_pend;
    if (thr_wr) np = 1'b0;
    else if (thr_drained || (ier_wr && thr_empty)) np = 1'b1;
    else if (iir_rd && m_iir[3:0] == 4'h2) np = 1'b0;
    m_iir  = exp_iir(ne, np);
    m_ier  = ne;
    m_pend = np;
    @(posedge clk);
    @(negedge clk);
    chk("R11 model iir", iir, m_iir);
    chk("R9 model irq", {7'b0, irq}, {7'b0, m_iir[3:0] != 4'h1});
    chk("R10 model ier", {4'b0, ier_q}, {4'b0, m_ier});
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1655_0A01));
    idle();
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    m_ier = 0; m_pend = 0; m_iir = 8'h01;
    chk("R1 reset iir", iir, 8'h01);
    chk("R1 reset irq", {7'b0, irq}, 8'h00);
    chk("R1 reset ier", {4'b0, ier_q}, 8'h00);

    // R10/R5: enable all while holding register empty -> pending set
    ier_wr = 1; ier_wr_data = 4'hF; thr_empty = 1; step();
    chk("R10 ier stored", {4'b0, ier_q}, 8'h0F);
    chk("R5 thre code", iir, 8'h02);
    chk("R9 irq high", {7'b0, irq}, 8'h01);

    // R6: read while showing 0x02 clears
    iir_rd = 1; step();
    chk("R6 read clears", iir, 8'h01);

    // R2: line status beats timeout and modem
    lsr_err = 4'b0100; timeout_pend = 1; msr_delta = 4'h3; rx_ready = 1; step();
    chk("R2 line wins", iir, 8'h06);

    // R3: timeout beats receive data
    timeout_pend = 1; rx_ready = 1; msr_delta = 4'h1; step();
    chk("R3 timeout", iir, 8'h0C);

    // R3: timeout gated by receive enable bit 0
    ier_wr = 1; ier_wr_data = 4'hE; timeout_pend = 1; step();
    chk("R3 timeout masked", iir, 8'h01);

    // R4/R8: FIFO mode trigger 8
    ier_wr = 1; ier_wr_data = 4'h1; fifo_en = 1; trig_sel = 2; rx_ready = 1;
    rx_count = 7; step();
    chk("R4 below level", iir, 8'hC1);
    fifo_en = 1; trig_sel = 2; rx_ready = 1; rx_count = 8; step();
    chk("R4 at level", iir, 8'hC4);
    chk("R8 fifo bits", {6'b0, iir[7:6]}, 8'h03);

    // R4: non-FIFO mode, ready alone
    rx_ready = 1; rx_count = 0; trig_sel = 3; step();
    chk("R4 no fifo", iir, 8'h04);

    // R7: modem cause
    ier_wr = 1; ier_wr_data = 4'h8; msr_delta = 4'h8; step();
    chk("R7 modem", iir, 8'h00);
    chk("R9 irq modem", {7'b0, irq}, 8'h01);

    // R6: read while a higher code masks pending leaves it set
    ier_wr = 1; ier_wr_data = 4'h3; thr_empty = 1; rx_ready = 1; step();
    chk("R6 masked by rx", iir, 8'h04);
    iir_rd = 1; rx_ready = 1; step();
    chk("R6 read other code", iir, 8'h04);
    step();
    chk("R6 pending kept", iir, 8'h02);

    // R5: write to holding register clears; drain pulse sets
    thr_wr = 1; iir_rd = 0; step();
    chk("R5 thr write clears", iir, 8'h01);
    thr_drained = 1; step();
    chk("R5 drained sets", iir, 8'h02);
    iir_rd = 1; thr_drained = 1; step();
    chk("R5 set beats read", iir, 8'h02);

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      ier_wr      = ($urandom % 6) == 0;
      ier_wr_data = 4'($urandom);
      thr_wr      = ($urandom % 8) == 0;
      thr_drained = ($urandom % 6) == 0;
      thr_empty   = ($urandom % 2) == 0;
      iir_rd      = ($urandom % 3) == 0;
      lsr_err     = (($urandom % 5) == 0) ? 4'($urandom) : 4'h0;
      timeout_pend = ($urandom % 5) == 0;
      rx_ready    = ($urandom % 3) == 0;
      rx_count    = CW'($urandom % (DEPTH + 1));
      trig_sel    = 2'($urandom);
      msr_delta   = (($urandom % 3) == 0) ? 4'($urandom) : 4'h0;
      fifo_en     = ($urandom % 2) == 0;
      step();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule